// File: doc/BRIEF.md
# Two-Slot Recent Translation Shortcut

This block keeps the two most recently completed address translations so that a repeat access can bypass the full translation lookup and its chain of fault checks. Each slot records the page it covers (virtual base and size), where that page sits in physical memory, whether the page may be written, whether accesses to it have side effects, the address-space identifier the translation was made under, and the table index of the entry it came from. The whole cache is tagged with a single copy of the translation-state word that was current when it was last filled. If the live state word no longer equals that copy, nothing hits. No per-slot flush is needed.

The request side is purely combinational. An aligned request whose address range overlaps a stored page, and whose identifier matches, produces a hit together with the composed physical address and an uncacheable flag. The full translator drives the fill port in the cycle after a successful lookup. The fill pushes the new translation into the front slot, moves the old front slot to the back, and records the request's current state word.

Top module: `xlate_shortcut`

## Requirements
- R1: After a synchronous reset the cache is invalid, both slots are empty, and no request hits until a fill has been made.
- R2: A request can hit only when the cache is valid and `req_state` equals the state word recorded by the latest fill.
- R3: A request whose address is not a multiple of `req_size` never hits. `req_size` is a nonzero power-of-two byte count.
- R4: A slot matches when its identifier equals `req_id`, its virtual base is below `req_addr + req_size`, and its virtual base plus its page size is above `req_addr`. The page size is 2 to the power `fill_shift` bytes.
- R5: A write request (`req_write` = 1) matches a slot only if that slot was filled with `fill_writable` = 1.
- R6: When both slots match, the front slot (the most recent fill) supplies the result.
- R7: On a hit, `paddr` is the slot's physical base with its low `fill_shift` bits cleared, ORed with the low `fill_shift` bits of `req_addr`. On a miss, `paddr` is 0 and `uncacheable` is 0.
- R8: On a hit, `uncacheable` is 1 when the slot's side-effect bit is set or bit 39 of its physical base is set.
- R9: A fill whose index is not already held puts the new translation in the front slot and moves the old front slot to the back slot. The old back slot is discarded.
- R10: A fill made while the cache is valid, whose `fill_idx` equals the index of an occupied slot, leaves both slots unchanged.
- R11: A fill with `fill_implicit` = 1 stores identifier 0 in the front slot, regardless of `fill_id`.
- R12: A fill made while the cache is invalid empties both slots before inserting, so afterwards only the new translation can hit.
- R13: Every fill records the current `req_state` and sets the cache valid, even when the slots are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 48 | Virtual address of the request |
| req_size | input | 5 | Access size in bytes (power of two) |
| req_write | input | 1 | Request is a store |
| req_id | input | 8 | Address-space identifier of the request |
| req_state | input | 64 | Current translation-state word |
| fill_en | input | 1 | Insert a translation at the next clock edge |
| fill_idx | input | 6 | Table index of the entry being inserted |
| fill_vbase | input | 48 | Virtual page base |
| fill_shift | input | 6 | log2 of the page size in bytes |
| fill_pbase | input | 48 | Physical page base |
| fill_writable | input | 1 | Page permits writes |
| fill_side_effect | input | 1 | Page has side effects |
| fill_id | input | 8 | Identifier the translation was made under |
| fill_implicit | input | 1 | Fill came from an implicit access; store identifier 0 |
| hit | output | 1 | Request was served by the cache |
| paddr | output | 48 | Physical address (0 on a miss) |
| uncacheable | output | 1 | Access must bypass data caches (0 on a miss) |

## Verification
The bench probes the edges of the overlap test. It checks the last aligned word inside a page, the word just below the base, and the first word past the end. An off-by-one comparison would either hit outside the page or drop a legal access. It fills two slots over the same page so that a wrong priority returns the older physical address. It also pushes a third and fourth translation to show that the oldest one is gone. A cache that never ages out would keep hitting there. It refills an index that is already held, with a different physical base, and a design that re-inserts would return the new base. It also checks implicit fills, state-word changes, misaligned requests and write permission. A cache that ignored any of these would hit where a miss is required.

// File: rtl/xs_pkg.sv
package xs_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 48;
    localparam int SZ_W   = 5;
    localparam int ID_W   = 8;
    localparam int ST_W   = 64;
    localparam int IX_W   = 6;
    localparam int SH_W   = 6;
    localparam int NSLOT  = 2;
    localparam int UC_BIT = 39;

    typedef struct packed {
        logic            used;
        logic [IX_W-1:0] idx;
        logic [VA_W-1:0] vbase;
        logic [SH_W-1:0] shift;
        logic [PA_W-1:0] pbase;
        logic            wr;
        logic            se;
        logic [ID_W-1:0] id;
    } slot_t;

    typedef struct packed {
        logic            hit;
        logic [PA_W-1:0] pa;
        logic            uc;
    } xlat_t;

    // Number of bytes in a page, one bit wider than a virtual address.
    function automatic logic [VA_W:0] page_bytes(input logic [SH_W-1:0] sh);
        logic [VA_W:0] one;
        one = '0;
        one[0] = 1'b1;
        return one << sh;
    endfunction

    // Mask selecting the in-page offset bits of a physical address.
    function automatic logic [PA_W-1:0] off_mask(input logic [SH_W-1:0] sh);
        logic [PA_W:0] one;
        logic [PA_W:0] m;
        one = '0;
        one[0] = 1'b1;
        m = (one << sh) - one;
        return m[PA_W-1:0];
    endfunction
endpackage

// File: rtl/xs_slot_match.sv
module xs_slot_match
    import xs_pkg::*;
(
    input  slot_t           slot,
    input  logic [VA_W-1:0] addr,
    input  logic [SZ_W-1:0] size,
    input  logic            write,
    input  logic [ID_W-1:0] id,
    output xlat_t           res
);
    logic [VA_W:0]   req_end;
    logic [VA_W:0]   pg_end;
    logic [VA_W:0]   base_x;
    logic [VA_W:0]   addr_x;
    logic [PA_W-1:0] mask;
    logic [PA_W-1:0] addr_p;
    logic            overlap;
    logic            perm_ok;

    always_comb begin
        base_x  = {1'b0, slot.vbase};
        addr_x  = {1'b0, addr};
        req_end = addr_x + {{(VA_W+1-SZ_W){1'b0}}, size};
        pg_end  = base_x + page_bytes(slot.shift);
        overlap = (base_x < req_end) && (pg_end > addr_x);
        perm_ok = !write || slot.wr;
        mask    = off_mask(slot.shift);
        addr_p  = PA_W'(addr);
        res.hit = slot.used && (slot.id == id) && overlap && perm_ok;
        res.pa  = (slot.pbase & ~mask) | (addr_p & mask);
        res.uc  = slot.se | slot.pbase[UC_BIT];
    end
endmodule

// File: rtl/xs_mru_fill.sv
module xs_mru_fill
    import xs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fill_en,
    input  logic [IX_W-1:0]       fill_idx,
    input  slot_t                 fill_slot,
    input  logic [ST_W-1:0]       cur_state,
    output slot_t [NSLOT-1:0]     slots_q,
    output logic                  valid_q,
    output logic [ST_W-1:0]       state_q
);
    slot_t [NSLOT-1:0] base;
    slot_t [NSLOT-1:0] slots_d;
    logic              present;

    always_comb begin
        base    = valid_q ? slots_q : '0;
        present = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (valid_q && slots_q[i].used && (slots_q[i].idx == fill_idx))
                present = 1'b1;
        end
        slots_d = base;
        if (!present) begin
            for (int i = NSLOT-1; i > 0; i--)
                slots_d[i] = base[i-1];
            slots_d[0] = fill_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            valid_q <= 1'b0;
            state_q <= '0;
        end else if (fill_en) begin
            slots_q <= slots_d;
            valid_q <= 1'b1;
            state_q <= cur_state;
        end
    end
endmodule

// File: rtl/xlate_shortcut.sv
module xlate_shortcut
    import xs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VA_W-1:0]  req_addr,
    input  logic [SZ_W-1:0]  req_size,
    input  logic             req_write,
    input  logic [ID_W-1:0]  req_id,
    input  logic [ST_W-1:0]  req_state,
    input  logic             fill_en,
    input  logic [IX_W-1:0]  fill_idx,
    input  logic [VA_W-1:0]  fill_vbase,
    input  logic [SH_W-1:0]  fill_shift,
    input  logic [PA_W-1:0]  fill_pbase,
    input  logic             fill_writable,
    input  logic             fill_side_effect,
    input  logic [ID_W-1:0]  fill_id,
    input  logic             fill_implicit,
    output logic             hit,
    output logic [PA_W-1:0]  paddr,
    output logic             uncacheable
);
    slot_t [NSLOT-1:0] slots_q;
    logic              cache_valid_q;
    logic [ST_W-1:0]   state_q;
    slot_t             new_slot;
    xlat_t             per_slot [NSLOT];
    xlat_t             pick;
    logic [VA_W-1:0]   size_mask;
    logic              aligned;
    logic              usable;

    always_comb begin
        new_slot.used  = 1'b1;
        new_slot.idx   = fill_idx;
        new_slot.vbase = fill_vbase;
        new_slot.shift = fill_shift;
        new_slot.pbase = fill_pbase;
        new_slot.wr    = fill_writable;
        new_slot.se    = fill_side_effect;
        new_slot.id    = fill_implicit ? '0 : fill_id;
    end

    xs_mru_fill u_fill (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_slot (new_slot),
        .cur_state (req_state),
        .slots_q   (slots_q),
        .valid_q   (cache_valid_q),
        .state_q   (state_q)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_match
        xs_slot_match u_match (
            .slot  (slots_q[g]),
            .addr  (req_addr),
            .size  (req_size),
            .write (req_write),
            .id    (req_id),
            .res   (per_slot[g])
        );
    end

    always_comb begin
        size_mask = VA_W'(req_size) - VA_W'(1);
        aligned   = (req_addr & size_mask) == '0;
        usable    = cache_valid_q && (state_q == req_state) && aligned;
        pick      = '0;
        for (int i = NSLOT-1; i >= 0; i--) begin
            if (per_slot[i].hit)
                pick = per_slot[i];
        end
        if (!usable)
            pick = '0;
        hit         = pick.hit;
        paddr       = pick.pa;
        uncacheable = pick.uc;
    end
endmodule

// File: rtl/xs_chk.sv
module xs_chk
    import xs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [VA_W-1:0] req_addr,
    input logic [SZ_W-1:0] req_size,
    input logic [ST_W-1:0] req_state,
    input logic            fill_en,
    input logic            hit,
    input logic [PA_W-1:0] paddr,
    input logic            uncacheable,
    input logic            cache_valid
);
    logic [VA_W-1:0] low_bits;
    assign low_bits = req_addr & (VA_W'(req_size) - VA_W'(1));

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit); // R1
    AST_STATE_GATE: assert property (@(posedge clk) disable iff (rst)
        ($past(hit) && !$past(fill_en) && (req_state != $past(req_state))) |-> !hit); // R2
    AST_MISALIGN_MISS: assert property (@(posedge clk) disable iff (rst)
        (low_bits != '0) |-> !hit); // R3
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (paddr == '0 && !uncacheable)); // R7
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> cache_valid); // R13
endmodule

bind xlate_shortcut xs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_state   (req_state),
    .fill_en     (fill_en),
    .hit         (hit),
    .paddr       (paddr),
    .uncacheable (uncacheable),
    .cache_valid (cache_valid_q)
);

// File: tb/tb_xlate_shortcut.sv
module tb_xlate_shortcut;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] req_addr = '0;
    logic [4:0]  req_size = 5'd4;
    logic        req_write = 1'b0;
    logic [7:0]  req_id = '0;
    logic [63:0] req_state = '0;
    logic        fill_en = 1'b0;
    logic [5:0]  fill_idx = '0;
    logic [47:0] fill_vbase = '0;
    logic [5:0]  fill_shift = '0;
    logic [47:0] fill_pbase = '0;
    logic        fill_writable = 1'b0;
    logic        fill_side_effect = 1'b0;
    logic [7:0]  fill_id = '0;
    logic        fill_implicit = 1'b0;
    logic        hit;
    logic [47:0] paddr;
    logic        uncacheable;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    bit          m_valid;
    logic [63:0] m_state;
    bit          m_used [2];
    int          m_ix   [2];
    logic [63:0] m_vb   [2];
    int          m_sh   [2];
    logic [63:0] m_pb   [2];
    bit          m_wr   [2];
    bit          m_se   [2];
    int          m_id   [2];

    always #2 clk = ~clk;

    xlate_shortcut dut (.*);

    task automatic model_clear();
        m_valid = 0;
        m_state = '0;
        for (int i = 0; i < 2; i++) begin
            m_used[i] = 0; m_ix[i] = 0; m_vb[i] = 0; m_sh[i] = 0;
            m_pb[i] = 0; m_wr[i] = 0; m_se[i] = 0; m_id[i] = 0;
        end
    endtask

    task automatic model_fill();
        bit found = 0;
        if (!m_valid) begin
            for (int i = 0; i < 2; i++) m_used[i] = 0;
        end
        for (int i = 0; i < 2; i++)
            if (m_valid && m_used[i] && m_ix[i] == int'(fill_idx)) found = 1;
        if (!found) begin
            m_used[1] = m_used[0]; m_ix[1] = m_ix[0]; m_vb[1] = m_vb[0];
            m_sh[1] = m_sh[0]; m_pb[1] = m_pb[0]; m_wr[1] = m_wr[0];
            m_se[1] = m_se[0]; m_id[1] = m_id[0];
            m_used[0] = 1; m_ix[0] = int'(fill_idx); m_vb[0] = 64'(fill_vbase);
            m_sh[0] = int'(fill_shift); m_pb[0] = 64'(fill_pbase);
            m_wr[0] = fill_writable; m_se[0] = fill_side_effect;
            m_id[0] = fill_implicit ? 0 : int'(fill_id);
        end
        m_valid = 1;
        m_state = req_state;
    endtask

    task automatic check1(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(string tag);
        bit          e_hit = 0;
        logic [63:0] e_pa = '0;
        bit          e_uc = 0;
        logic [63:0] a, sz, pg;
        #1;
        a  = 64'(req_addr);
        sz = 64'(req_size);
        if (m_valid && m_state == req_state && (a % sz) == 0) begin
            for (int i = 0; i < 2; i++) begin
                pg = 64'd1 << m_sh[i];
                if (!e_hit && m_used[i] && m_id[i] == int'(req_id) &&
                    m_vb[i] < a + sz && m_vb[i] + pg > a && (!req_write || m_wr[i])) begin
                    e_hit = 1;
                    e_pa  = (m_pb[i] / pg) * pg + (a % pg);
                    e_uc  = m_se[i] || m_pb[i][39];
                end
            end
        end
        check1(tag, "hit", 64'(hit), 64'(e_hit));
        check1(tag, "paddr", 64'(paddr), e_pa);
        check1(tag, "uncacheable", 64'(uncacheable), 64'(e_uc));
        @(posedge clk);
        if (rst) model_clear();
        else if (fill_en) model_fill();
        @(negedge clk);
    endtask

    task automatic req(logic [47:0] a, logic [4:0] s, bit w, logic [7:0] id, string tag);
        req_addr = a; req_size = s; req_write = w; req_id = id;
        tick(tag);
    endtask

    task automatic fill(logic [5:0] ix, logic [47:0] vb, logic [5:0] sh, logic [47:0] pb,
                        bit wr, bit se, logic [7:0] id, bit imp, string tag);
        fill_en = 1; fill_idx = ix; fill_vbase = vb; fill_shift = sh; fill_pbase = pb;
        fill_writable = wr; fill_side_effect = se; fill_id = id; fill_implicit = imp;
        tick(tag);
        fill_en = 0; fill_implicit = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL all requirements: watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        model_clear();
        rst = 0;
        req_state = 64'h5151;
        req(48'h1010, 4, 0, 8'd7, "R1");
        // page A: 4 KiB, read-only, id 7
        fill(6'd1, 48'h1000, 6'd12, 48'hAB_C000, 0, 0, 8'd7, 0, "R9");
        req(48'h1010, 4, 0, 8'd7, "R4");
        req(48'h1FFC, 4, 0, 8'd7, "R4");
        req(48'h2000, 4, 0, 8'd7, "R4");
        req(48'h0FF8, 8, 0, 8'd7, "R4");
        req(48'h1010, 4, 0, 8'd5, "R4");
        req(48'h1010, 4, 1, 8'd7, "R5");
        req(48'h1012, 4, 0, 8'd7, "R3");
        req(48'h1004, 8, 0, 8'd7, "R3");
        req_state = 64'h6262;
        req(48'h1010, 4, 0, 8'd7, "R2");
        req_state = 64'h5151;
        req(48'h1010, 4, 0, 8'd7, "R2");
        // page B: same page, writable, physical bit 39 set
        fill(6'd2, 48'h1000, 6'd12, 48'h80_0000_5000, 1, 0, 8'd7, 0, "R9");
        req(48'h1010, 4, 0, 8'd7, "R6");
        req(48'h1020, 8, 1, 8'd7, "R8");
        // page C: 64 KiB side-effect page
        fill(6'd3, 48'h40000, 6'd16, 48'h123_0000, 0, 1, 8'd9, 0, "R9");
        req(48'h4ABC8, 8, 0, 8'd9, "R7");
        req(48'h1010, 4, 0, 8'd7, "R9");
        fill(6'd4, 48'h8000, 6'd12, 48'h77_7000, 1, 0, 8'd3, 0, "R9");
        req(48'h1010, 4, 0, 8'd7, "R9");
        req(48'h8FF0, 16, 1, 8'd3, "R9");
        req(48'h40010, 4, 0, 8'd9, "R9");
        // same index as C again with a different base: no change
        fill(6'd3, 48'h40000, 6'd16, 48'h999_0000, 0, 0, 8'd9, 0, "R10");
        req(48'h40010, 4, 0, 8'd9, "R10");
        req(48'h8010, 4, 0, 8'd3, "R10");
        // implicit fill
        fill(6'd5, 48'hA000, 6'd12, 48'h5_5000, 1, 0, 8'h22, 1, "R11");
        req(48'hA044, 4, 0, 8'h00, "R11");
        req(48'hA044, 4, 0, 8'h22, "R11");
        // fill under a new state word while valid
        req_state = 64'hC0DE;
        fill(6'd6, 48'hC000, 6'd12, 48'h6_6000, 0, 0, 8'd4, 0, "R13");
        req(48'hC008, 8, 0, 8'd4, "R13");
        req(48'hA044, 4, 0, 8'h00, "R13");
        req_state = 64'h5151;
        req(48'hC008, 8, 0, 8'd4, "R2");
        // reset then one fill
        rst = 1;
        tick("R1");
        tick("R1");
        rst = 0;
        req_state = 64'hC0DE;
        req(48'hC008, 8, 0, 8'd4, "R1");
        fill(6'd7, 48'hE000, 6'd12, 48'h1_E000, 0, 0, 8'd2, 0, "R12");
        req(48'hE100, 4, 0, 8'd2, "R12");
        req(48'hC008, 8, 0, 8'd4, "R12");
        req(48'hA044, 4, 0, 8'h00, "R12");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule